// File: doc/BRIEF.md
# ECC Error Injection Unit

This block sits in the write path of a memory controller, after the ECC encoder. It alters the check bits of chosen write accesses so that the detection and correction logic later in the system can be tested with known faults. Each access arrives with its decoded DRAM coordinates: module within its channel, rank, channel, bank, page and column. The access also carries a write strobe and two 16-bit check words, one for the low data section and one for the high data section. The block returns the two check words, which are corrupted when an injection fires and unchanged otherwise. It also drives a separate parity-flip bit.

Software sets up an injection through a small register port. It writes a match value and a wildcard flag for each coordinate. It then writes an XOR mask for the check bits, a section select, an injection type and an arm (enable) register. Every register can be read back. An injection fires on a write whose coordinates equal every field that is not a wildcard. A type bit chooses between two behaviours. In one-shot mode the block disarms itself after the first hit. In repeat mode it corrupts every matching write for as long as it stays armed. The check-word outputs are combinational in the access inputs. A change to the arm state takes effect from the next clock.

Top module: `ecc_inject_unit`

## Requirements
- R1: After reset, all six match fields read as wildcard (bit 31 = 1, value 0). The mask, section select, type and enable registers read 0, and the check words pass through unchanged with `par_flip` = 0.
- R2: The register port reads back what was written. Addresses 0 to 5 hold the module, rank, channel, bank, page and column fields: the value sits in the low bits, truncated to the field width, and the wildcard flag sits in bit 31. Address 6 holds the ECC mask, 7 the section select, 8 the type and 9 the enable. Any other address reads 0.
- R3: Writing a nonzero value to address 9 arms the unit, and enable then reads 1 from the next cycle. Writing zero disarms it.
- R4: An armed write matches only when every field whose wildcard flag is clear equals the corresponding access coordinate. Fields flagged as wildcard have no effect on the match.
- R5: While `wr_stb` is low or the unit is disarmed, both check words pass unchanged and `par_flip` is 0.
- R6: With type bit 1 (ECC) set and type bit 2 clear, a matching write has its low check word XORed with the mask when select bit 0 is set, and its high check word XORed when select bit 1 is set. So select value 1 targets the low section, 2 the high section and 3 both. With neither type bit 1 nor type bit 2 set, nothing is altered and the enable stays set.
- R7: With type bit 2 (parity) set, a matching write raises `par_flip` and leaves both check words unchanged, even when bit 1 is also set.
- R8: With type bit 0 (repeat) clear, the enable clears at the clock edge that ends the first write that fires. Later matching writes pass unchanged.
- R9: With type bit 0 set, every matching write fires and the enable stays set.
- R10: A register write to address 9 in the same cycle as a firing write decides the next enable value, and takes priority over the one-shot clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| wr_stb | input | 1 | Current access is a write |
| acc_dimm | input | 2 | Module index within its channel |
| acc_rank | input | 2 | Rank |
| acc_chan | input | 2 | Channel |
| acc_bank | input | 3 | Bank |
| acc_page | input | 16 | Page (row) |
| acc_col | input | 11 | Column |
| chk_lo_in | input | 16 | Check word, low section |
| chk_hi_in | input | 16 | Check word, high section |
| chk_lo_out | output | 16 | Possibly corrupted low check word |
| chk_hi_out | output | 16 | Possibly corrupted high check word |
| par_flip | output | 1 | Invert the parity bit of this write |

## Verification
On every cycle, the assertions check the following: words pass untouched when the unit is idle or disarmed, a parity injection never disturbs the check words, the arm and disarm effect of enable writes, the one-shot self-clear, and the repeat-mode hold of the enable. The bench scenarios cover the rest. These are the per-field wildcard matching, the section steering of the mask for each select value, the parity-over-ECC priority, the truncation and readback of every register, and the same-cycle conflict between an enable write and a one-shot hit. The bench compares all of these against a behavioural model on every clock.

// File: rtl/ecc_inj_pkg.sv
// Shared constants for the ECC error injection unit.
// Assumes a register port with a 4-bit address; field order fixes register addresses.
package ecc_inj_pkg;
    localparam int NFIELD = 6;
    localparam int F_DIMM = 0;
    localparam int F_RANK = 1;
    localparam int F_CHAN = 2;
    localparam int F_BANK = 3;
    localparam int F_PAGE = 4;
    localparam int F_COL  = 5;

    localparam logic [3:0] RA_MASK = 4'd6;
    localparam logic [3:0] RA_SEL  = 4'd7;
    localparam logic [3:0] RA_TYPE = 4'd8;
    localparam logic [3:0] RA_EN   = 4'd9;

    localparam int TY_RPT = 0;
    localparam int TY_ECC = 1;
    localparam int TY_PAR = 2;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ecc_inj_regs.sv
// Configuration registers of the injection unit: match fields with wildcard
// flags, ECC mask, section select, type and enable. Assumes DATA_W > FW_MAX.
// The enable clears itself on a one-shot hit unless software writes it that cycle.
module ecc_inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int FW_MAX = 16,
    parameter int CHK_W  = 16,
    parameter int DATA_W = 32,
    parameter int FW [NFIELD] = '{default: 1}
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [3:0]                     cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [DATA_W-1:0]              cfg_rdata,
    input  logic                           fire,
    output logic [NFIELD-1:0][FW_MAX-1:0]  m_val,
    output logic [NFIELD-1:0]              m_any,
    output logic [CHK_W-1:0]               ecc_mask,
    output logic [1:0]                     sec_sel,
    output logic [2:0]                     inj_type,
    output logic                           inj_en
);
    function automatic logic [FW_MAX-1:0] fmask(input int w);
        return FW_MAX'((64'd1 << w) - 64'd1);
    endfunction

    // Register updates: software writes, then the one-shot self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_val    <= '0;
            m_any    <= '1;
            ecc_mask <= '0;
            sec_sel  <= '0;
            inj_type <= '0;
            inj_en   <= 1'b0;
        end else begin
            for (int i = 0; i < NFIELD; i++) begin
                if (cfg_we && cfg_addr == 4'(i)) begin
                    m_val[i] <= cfg_wdata[FW_MAX-1:0] & fmask(FW[i]);
                    m_any[i] <= cfg_wdata[DATA_W-1];
                end
            end
            if (cfg_we && cfg_addr == RA_MASK) ecc_mask <= cfg_wdata[CHK_W-1:0];
            if (cfg_we && cfg_addr == RA_SEL)  sec_sel  <= cfg_wdata[1:0];
            if (cfg_we && cfg_addr == RA_TYPE) inj_type <= cfg_wdata[2:0];
            if (cfg_we && cfg_addr == RA_EN)
                inj_en <= |cfg_wdata;
            else if (fire && !inj_type[TY_RPT])
                inj_en <= 1'b0;
        end
    end

    // Readback multiplexer for the addressed register.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NFIELD; i++) begin
            if (cfg_addr == 4'(i)) begin
                cfg_rdata[FW_MAX-1:0] = m_val[i];
                cfg_rdata[DATA_W-1]   = m_any[i];
            end
        end
        case (cfg_addr)
            RA_MASK: cfg_rdata = DATA_W'(ecc_mask);
            RA_SEL:  cfg_rdata = DATA_W'(sec_sel);
            RA_TYPE: cfg_rdata = DATA_W'(inj_type);
            RA_EN:   cfg_rdata = DATA_W'(inj_en);
            default: ;
        endcase
    end
endmodule

// File: rtl/ecc_inj_match.sv
// Address matcher: one comparator per decoded coordinate, each bypassed by
// its wildcard flag. Assumes access fields are zero-extended to FW_MAX.
module ecc_inj_match
    import ecc_inj_pkg::*;
#(
    parameter int FW_MAX = 16
) (
    input  logic [NFIELD-1:0][FW_MAX-1:0] m_val,
    input  logic [NFIELD-1:0]             m_any,
    input  logic [NFIELD-1:0][FW_MAX-1:0] acc_f,
    input  logic                          wr_stb,
    input  logic                          inj_en,
    output logic                          hit
);
    logic [NFIELD-1:0] fhit;

    // Per-field compare, forced true by the wildcard flag.
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        assign fhit[g] = m_any[g] | (m_val[g] == acc_f[g]);
    end

    // An armed write hits only if every field agrees.
    assign hit = wr_stb & inj_en & (&fhit);
endmodule

// File: rtl/ecc_inj_corrupt.sv
// Corruption stage: on a hit, XORs the mask into the selected check-word
// sections (ECC type) or raises the parity flip (parity type, which wins).
// Assumes section index 0 is the low half and 1 the high half.
module ecc_inj_corrupt
    import ecc_inj_pkg::*;
#(
    parameter int CHK_W = 16
) (
    input  logic                  hit,
    input  logic [CHK_W-1:0]      ecc_mask,
    input  logic [1:0]            sec_sel,
    input  logic [2:0]            inj_type,
    input  logic [1:0][CHK_W-1:0] chk_in,
    output logic [1:0][CHK_W-1:0] chk_out,
    output logic                  par_flip,
    output logic                  fire
);
    logic par_mode;
    logic ecc_mode;

    // Mode decode: parity takes priority over the ECC mask.
    assign par_mode = inj_type[TY_PAR];
    assign ecc_mode = inj_type[TY_ECC] & ~par_mode;

    // Per-section mask application, steered by the select bits.
    for (genvar s = 0; s < 2; s++) begin : g_sec
        assign chk_out[s] = chk_in[s] ^ ((hit && ecc_mode && sec_sel[s]) ? ecc_mask : '0);
    end

    // Parity flip and the firing event that drives the one-shot clear.
    assign par_flip = hit & par_mode;
    assign fire     = hit & (par_mode | inj_type[TY_ECC]);
endmodule

// File: rtl/ecc_inject_unit.sv
// ECC error injection unit top: registers, coordinate matcher and
// corruption stage. Check-word outputs are combinational in the access inputs.
module ecc_inject_unit
    import ecc_inj_pkg::*;
#(
    parameter int DIMM_W = 2,
    parameter int RANK_W = 2,
    parameter int CHAN_W = 2,
    parameter int BANK_W = 3,
    parameter int PAGE_W = 16,
    parameter int COL_W  = 11,
    parameter int CHK_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              wr_stb,
    input  logic [DIMM_W-1:0] acc_dimm,
    input  logic [RANK_W-1:0] acc_rank,
    input  logic [CHAN_W-1:0] acc_chan,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [COL_W-1:0]  acc_col,
    input  logic [CHK_W-1:0]  chk_lo_in,
    input  logic [CHK_W-1:0]  chk_hi_in,
    output logic [CHK_W-1:0]  chk_lo_out,
    output logic [CHK_W-1:0]  chk_hi_out,
    output logic              par_flip
);
    localparam int FW_MAX = max_of(max_of(max_of(DIMM_W, RANK_W), max_of(CHAN_W, BANK_W)),
                                   max_of(PAGE_W, COL_W));
    localparam int FW_TAB [NFIELD] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};

    logic [NFIELD-1:0][FW_MAX-1:0] m_val;
    logic [NFIELD-1:0]             m_any;
    logic [NFIELD-1:0][FW_MAX-1:0] acc_f;
    logic [CHK_W-1:0]              ecc_mask;
    logic [1:0]                    sec_sel;
    logic [2:0]                    inj_type;
    logic                          inj_en;
    logic                          hit;
    logic                          fire;
    logic [1:0][CHK_W-1:0]         chk_in;
    logic [1:0][CHK_W-1:0]         chk_out;

    // Gather access coordinates in register order, zero-extended.
    assign acc_f[F_DIMM] = FW_MAX'(acc_dimm);
    assign acc_f[F_RANK] = FW_MAX'(acc_rank);
    assign acc_f[F_CHAN] = FW_MAX'(acc_chan);
    assign acc_f[F_BANK] = FW_MAX'(acc_bank);
    assign acc_f[F_PAGE] = FW_MAX'(acc_page);
    assign acc_f[F_COL]  = FW_MAX'(acc_col);

    // Section packing: index 0 low, index 1 high.
    assign chk_in[0]  = chk_lo_in;
    assign chk_in[1]  = chk_hi_in;
    assign chk_lo_out = chk_out[0];
    assign chk_hi_out = chk_out[1];

    ecc_inj_regs #(
        .FW_MAX(FW_MAX), .CHK_W(CHK_W), .DATA_W(DATA_W), .FW(FW_TAB)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
        .m_val(m_val), .m_any(m_any), .ecc_mask(ecc_mask),
        .sec_sel(sec_sel), .inj_type(inj_type), .inj_en(inj_en)
    );

    ecc_inj_match #(.FW_MAX(FW_MAX)) match_i (
        .m_val(m_val), .m_any(m_any), .acc_f(acc_f),
        .wr_stb(wr_stb), .inj_en(inj_en), .hit(hit)
    );

    ecc_inj_corrupt #(.CHK_W(CHK_W)) corrupt_i (
        .hit(hit), .ecc_mask(ecc_mask), .sec_sel(sec_sel), .inj_type(inj_type),
        .chk_in(chk_in), .chk_out(chk_out), .par_flip(par_flip), .fire(fire)
    );
endmodule

// File: rtl/ecc_inject_sva.sv
// Assertion checker for ecc_inject_unit, attached by bind below.
// Assumes the enable register lives at address 9 and type bit 0 is repeat.
module ecc_inject_sva #(
    parameter int CHK_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [3:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              wr_stb,
    input logic [CHK_W-1:0]  chk_lo_in,
    input logic [CHK_W-1:0]  chk_hi_in,
    input logic [CHK_W-1:0]  chk_lo_out,
    input logic [CHK_W-1:0]  chk_hi_out,
    input logic              par_flip,
    input logic              fire,
    input logic              inj_en,
    input logic [2:0]        inj_type
);
    logic en_wr;
    assign en_wr = cfg_we && (cfg_addr == 4'd9);

    a_r5_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb || !inj_en) |-> (chk_lo_out == chk_lo_in && chk_hi_out == chk_hi_in && !par_flip));

    a_r7_parity_words_kept: assert property (@(posedge clk) disable iff (!rst_n)
        par_flip |-> (chk_lo_out == chk_lo_in && chk_hi_out == chk_hi_in));

    // R3 and R10: a nonzero enable write arms the unit even against a one-shot hit.
    a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && cfg_wdata != '0) |=> inj_en);

    a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && cfg_wdata == '0) |=> !inj_en);

    a_r8_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !inj_type[0] && !en_wr) |=> !inj_en);

    a_r9_repeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && inj_type[0] && !en_wr) |=> inj_en);
endmodule

bind ecc_inject_unit ecc_inject_sva #(.CHK_W(CHK_W), .DATA_W(DATA_W)) sva_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_stb(wr_stb), .chk_lo_in(chk_lo_in),
    .chk_hi_in(chk_hi_in), .chk_lo_out(chk_lo_out), .chk_hi_out(chk_hi_out),
    .par_flip(par_flip), .fire(fire), .inj_en(inj_en), .inj_type(inj_type)
);

// File: tb/ecc_inject_unit_tb.sv
// Self-checking bench: behavioural model stepped with the clock, compared every cycle.
module ecc_inject_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wr_stb = 1'b0;
    logic [1:0]  acc_dimm = '0;
    logic [1:0]  acc_rank = '0;
    logic [1:0]  acc_chan = '0;
    logic [2:0]  acc_bank = '0;
    logic [15:0] acc_page = '0;
    logic [10:0] acc_col = '0;
    logic [15:0] chk_lo_in = '0;
    logic [15:0] chk_hi_in = '0;
    logic [15:0] chk_lo_out;
    logic [15:0] chk_hi_out;
    logic        par_flip;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [31:0] m_val [6];
    bit          m_any [6];
    logic [15:0] m_mask;
    logic [1:0]  m_sel;
    logic [2:0]  m_typ;
    bit          m_en;
    int          fw [6] = '{2, 2, 2, 3, 16, 11};

    always #10 clk = ~clk;

    ecc_inject_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wr_stb(wr_stb),
        .acc_dimm(acc_dimm), .acc_rank(acc_rank), .acc_chan(acc_chan),
        .acc_bank(acc_bank), .acc_page(acc_page), .acc_col(acc_col),
        .chk_lo_in(chk_lo_in), .chk_hi_in(chk_hi_in),
        .chk_lo_out(chk_lo_out), .chk_hi_out(chk_hi_out), .par_flip(par_flip)
    );

    function automatic logic [31:0] fld(input int i);
        case (i)
            0: return 32'(acc_dimm);
            1: return 32'(acc_rank);
            2: return 32'(acc_chan);
            3: return 32'(acc_bank);
            4: return 32'(acc_page);
            default: return 32'(acc_col);
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        if (a < 6) return {m_any[a], 31'(m_val[a])};
        case (a)
            6: return 32'(m_mask);
            7: return 32'(m_sel);
            8: return 32'(m_typ);
            9: return 32'(m_en);
            default: return 32'd0;
        endcase
    endfunction

    // One cycle: compare outputs just before the edge, then advance the model.
    task automatic step(input string tag);
        bit hit, par, ecc, fire;
        logic [15:0] elo, ehi;
        logic [31:0] erd;
        #8;
        hit = m_en && wr_stb;
        for (int i = 0; i < 6; i++)
            if (!m_any[i] && m_val[i] != fld(i)) hit = 0;
        par  = hit && m_typ[2];
        ecc  = hit && !m_typ[2] && m_typ[1];
        fire = hit && (m_typ[1] || m_typ[2]);
        elo  = chk_lo_in ^ ((ecc && m_sel[0]) ? m_mask : 16'h0);
        ehi  = chk_hi_in ^ ((ecc && m_sel[1]) ? m_mask : 16'h0);
        erd  = exp_rd(cfg_addr);
        checks++;
        if (chk_lo_out !== elo || chk_hi_out !== ehi || par_flip !== par) begin
            errors++;
            $display("FAIL %s: words lo=%h hi=%h par=%b expected lo=%h hi=%h par=%b",
                     tag, chk_lo_out, chk_hi_out, par_flip, elo, ehi, par);
        end
        checks++;
        if (cfg_rdata !== erd) begin
            errors++;
            $display("FAIL %s: rdata[%0d]=%h expected %h", tag, cfg_addr, cfg_rdata, erd);
        end
        if (cfg_we) begin
            if (cfg_addr < 6) begin
                m_val[cfg_addr] = cfg_wdata & ((32'd1 << fw[cfg_addr]) - 32'd1);
                m_any[cfg_addr] = cfg_wdata[31];
            end else if (cfg_addr == 6) m_mask = cfg_wdata[15:0];
            else if (cfg_addr == 7) m_sel = cfg_wdata[1:0];
            else if (cfg_addr == 8) m_typ = cfg_wdata[2:0];
            else if (cfg_addr == 9) m_en = (cfg_wdata != 0);
        end
        if (!(cfg_we && cfg_addr == 9) && fire && !m_typ[0]) m_en = 0;
        @(negedge clk);
        #1;
    endtask

    task automatic cfgw(input logic [3:0] a, input logic [31:0] d, input string tag);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; wr_stb = 0;
        step(tag);
        cfg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cfg_we = 0; cfg_addr = a; wr_stb = 0;
        step(tag);
    endtask

    task automatic acc(input logic [1:0] d, input logic [1:0] r, input logic [1:0] c,
                       input logic [2:0] b, input logic [15:0] p, input logic [10:0] col,
                       input logic w, input string tag);
        acc_dimm = d; acc_rank = r; acc_chan = c; acc_bank = b; acc_page = p; acc_col = col;
        chk_lo_in = 16'h1111 + 16'(checks); chk_hi_in = 16'h2222 ^ 16'(checks * 7);
        wr_stb = w; cfg_addr = 4'd9;
        step(tag);
        wr_stb = 0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_any[i] = 1; end
        m_mask = 0; m_sel = 0; m_typ = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        for (int a = 0; a < 10; a++) rd(4'(a), "R1");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R1");
        // R2 configure and read back, including truncation
        cfgw(0, 32'h8000_0000, "R2");
        cfgw(1, 32'h0000_00F2, "R2");
        cfgw(2, 32'h3, "R2");
        cfgw(3, 32'h5, "R2");
        cfgw(4, 32'h1234, "R2");
        cfgw(5, 32'hF8AB, "R2");
        cfgw(6, 32'hA5A5, "R2");
        cfgw(7, 32'h1, "R2");
        cfgw(8, 32'h3, "R2");
        for (int a = 0; a < 9; a++) rd(4'(a), "R2");
        rd(4'd12, "R2");
        // R3 arm, R5 disarmed pass before
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R5");
        cfgw(9, 32'h5, "R3");
        rd(9, "R3");
        // R6 low section, R9 repeat
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R6");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R9");
        rd(9, "R9");
        // R4 wildcard and mismatches
        acc(0, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R4");
        acc(1, 2, 3, 4, 16'h1234, 11'h0ab, 1, "R4");
        acc(1, 2, 3, 5, 16'h1235, 11'h0ab, 1, "R4");
        acc(1, 1, 3, 5, 16'h1234, 11'h0ab, 1, "R4");
        acc(1, 2, 3, 5, 16'h1234, 11'h0aa, 1, "R4");
        // R5 no strobe
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 0, "R5");
        // R6 section steering
        cfgw(7, 32'h2, "R6");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R6");
        cfgw(7, 32'h3, "R6");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R6");
        cfgw(7, 32'h0, "R6");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R6");
        // R7 parity one-shot, R8 self-clear
        cfgw(7, 32'h3, "R7");
        cfgw(8, 32'h4, "R7");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R7");
        rd(9, "R8");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R8");
        // R8 ECC one-shot after a non-matching write
        cfgw(8, 32'h2, "R8");
        cfgw(9, 32'h1, "R8");
        acc(1, 2, 3, 4, 16'h1234, 11'h0ab, 1, "R8");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R8");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R8");
        rd(9, "R8");
        // R10 enable write in the same cycle as a one-shot hit
        cfgw(9, 32'h1, "R10");
        cfg_we = 1; cfg_wdata = 32'h1;
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R10");
        cfg_we = 0;
        rd(9, "R10");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R10");
        rd(9, "R10");
        // R6 no type bits: nothing changes, enable kept
        cfgw(8, 32'h0, "R6");
        cfgw(9, 32'h1, "R6");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R6");
        rd(9, "R6");
        // R7 parity wins over ECC
        cfgw(8, 32'h6, "R7");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R7");
        rd(9, "R7");
        // R3 disarm
        cfgw(8, 32'h3, "R3");
        cfgw(9, 32'h1, "R3");
        cfgw(9, 32'h0, "R3");
        rd(9, "R3");
        acc(1, 2, 3, 5, 16'h1234, 11'h0ab, 1, "R3");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule